// File: doc/BRIEF.md
# DAC Register Bank Reset and Clear Sequencer

This block initialises and clears the register bank of a multi-channel, 12-bit voltage-output DAC. Three events start a sequence. The first is the release of the chip's synchronous reset, which counts as power-on. The second is a falling edge on the external reset line. The third is a low level on the external clear line. A reset sequence walks every channel in turn. For each channel it writes four registers through a single write port: offset, gain, input and DAC. A clear sequence walks the same channels but only writes each DAC register, using the value of a clear register that is held outside this block.

While a sequence runs, `busy_n` is low and `lockout` is high. The host interfaces use `lockout` to stop accepting traffic. Load-DAC requests that arrive during this time are dropped. The FIFO-enable strap is captured when each sequence completes, and the captured value is held until the next sequence completes. The external reset and clear lines, and the strap, are asynchronous. Each passes through a two-flop synchroniser before any decision is made on it.

Top module: `dac_init_sequencer`

## Requirements
- R1: While `rst_n` is low, `busy_n` is 0, `lockout` is 1, `fifo_en` is 0 and `wr_en` is 0. After `rst_n` rises, a full reset sequence runs at once. It starts on the first clock edge with `rst_n` high, so `busy_n` stays low for a further NUM_CH*STEP_CYCLES cycles.
- R2: A reset sequence starts only on a high-to-low transition of `reset_pin_n`. `busy_n` goes low on the third rising clock edge after the transition. Holding `reset_pin_n` low, or raising it, starts nothing. Edges on `reset_pin_n` while a reset sequence runs are ignored.
- R3: Each reset or clear sequence holds `busy_n` low, and `lockout` high, for exactly NUM_CH*STEP_CYCLES clock cycles.
- R4: In a reset sequence, channel k is written in sequence cycles k*STEP_CYCLES+0 to +3. The writes use register codes on `wr_reg` in this order: 0 offset (data OFFSET_DEFAULT, default 0), 1 gain (data GAIN_DEFAULT, default all ones, 0xFFF), 2 input (data 0), 3 DAC (data 0). No write occurs outside a sequence.
- R5: When the block is idle, a low level on `clear_n` starts a clear sequence on the third rising edge after the line falls. This sequence writes only register code 3 (DAC), once per channel, in cycle k*STEP_CYCLES, with data equal to `clr_value`. Offset, gain and input registers are left untouched.
- R6: Both kinds of sequence visit channels 0 to NUM_CH-1 in ascending order, spending STEP_CYCLES clocks on each channel.
- R7: A falling edge of `reset_pin_n` during a clear sequence aborts the clear. A full reset sequence then starts from channel 0, and `busy_n` does not rise in between.
- R8: A low `clear_n` during a reset sequence has no effect if it is released before the sequence ends. If it is still low when the sequence ends, a clear sequence starts after one idle cycle.
- R9: `ldac_out` follows `ldac_in` only while `busy_n` is 1. Requests made while `busy_n` is 0 are discarded and never appear later.
- R10: `fifo_en` takes the synchronised `fifo_strap` value on the cycle a reset or clear sequence completes, and holds it at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release acts as power-on |
| reset_pin_n | input | 1 | Asynchronous external reset line, acts on falling edges |
| clear_n | input | 1 | Asynchronous external clear line, active low level |
| fifo_strap | input | 1 | Asynchronous FIFO-enable strap |
| clr_value | input | DATA_W | Contents of the user clear register |
| ldac_in | input | 1 | Load-DAC request from the host side |
| busy_n | output | 1 | Low while a sequence runs |
| lockout | output | 1 | High while a sequence runs; disables host interfaces |
| ldac_out | output | 1 | Load-DAC request passed on while idle |
| fifo_en | output | 1 | Captured FIFO-enable strap |
| wr_en | output | 1 | Register bank write strobe |
| wr_ch | output | $clog2(NUM_CH) | Channel being written |
| wr_reg | output | 2 | Register code: 0 offset, 1 gain, 2 input, 3 DAC |
| wr_data | output | DATA_W | Write data |

## Verification
An internal fault in the channel or step counters shows up first on the write port. A write appears in a cycle that does not equal channel*STEP_CYCLES plus register code, counted from the fall of `busy_n`, or a channel number skips. Either shows within one step of the fault. A fault in the mode state shows as a `busy_n` interval that is not exactly NUM_CH*STEP_CYCLES cycles long, as a clear that writes non-DAC registers, or as a reset that never starts or starts twice. These are visible at the end of the sequence, or within three cycles of a line edge. A bad capture of the strap shows on `fifo_en` at the first idle cycle after completion.

// File: rtl/dac_seq_pkg.sv
// Package: shared types for the DAC reset/clear sequencer.
// Holds the sequencer mode encoding and the register codes used on the
// write port. Assumes a bank of four registers per channel.
package dac_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PWRUP = 2'd1,
        SEQ_RESET = 2'd2,
        SEQ_CLEAR = 2'd3
    } seq_mode_t;

    localparam logic [1:0] REG_OFFSET = 2'd0;
    localparam logic [1:0] REG_GAIN   = 2'd1;
    localparam logic [1:0] REG_INPUT  = 2'd2;
    localparam logic [1:0] REG_DAC    = 2'd3;

endpackage

// File: rtl/dac_seq_sync.sv
// Module: dac_seq_sync
// Two-flop synchroniser for a vector of independent asynchronous lines.
// Assumes each bit is a slow level signal; no multi-bit coherence implied.
// RESET_VAL gives the inactive level loaded under reset.
module dac_seq_sync #(
    parameter int unsigned       WIDTH     = 3,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic meta;
            logic stab;

            // Purpose: two-stage capture of one asynchronous line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta <= RESET_VAL[i];
                    stab <= RESET_VAL[i];
                end else begin
                    meta <= d[i];
                    stab <= meta;
                end
            end

            assign q[i] = stab;
        end
    endgenerate

endmodule

// File: rtl/dac_seq_ctrl.sv
// Module: dac_seq_ctrl
// Mode state machine with channel and step counters.
// A reset edge wins over a clear level and aborts a running clear.
// Edges arriving during a reset walk are dropped. The strap is captured
// when a walk completes. Assumes STEP_CYCLES >= 4 and NUM_CH >= 2.
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 32,
    parameter int unsigned STEP_CYCLES = 8,
    localparam int unsigned CH_W       = $clog2(NUM_CH),
    localparam int unsigned CNT_W      = $clog2(STEP_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_fall,
    input  logic             clear_low,
    input  logic             strap_s,
    output seq_mode_t        mode,
    output logic [CH_W-1:0]  ch,
    output logic [CNT_W-1:0] cnt,
    output logic             fifo_en
);

    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYCLES - 1);

    logic step_end;
    logic walk_end;

    // Purpose: flag the last cycle of a channel step and of a whole walk.
    always_comb begin
        step_end = (cnt == LAST_CNT);
        walk_end = step_end && (ch == LAST_CH);
    end

    // Purpose: mode transitions, counter advance and strap capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= SEQ_PWRUP;
            ch      <= '0;
            cnt     <= '0;
            fifo_en <= 1'b0;
        end else begin
            case (mode)
                SEQ_PWRUP: begin
                    mode <= SEQ_RESET;
                    ch   <= '0;
                    cnt  <= '0;
                end
                SEQ_IDLE: begin
                    ch  <= '0;
                    cnt <= '0;
                    if (reset_fall) begin
                        mode <= SEQ_RESET;
                    end else if (clear_low) begin
                        mode <= SEQ_CLEAR;
                    end
                end
                SEQ_RESET, SEQ_CLEAR: begin
                    if (mode == SEQ_CLEAR && reset_fall) begin
                        mode <= SEQ_RESET;
                        ch   <= '0;
                        cnt  <= '0;
                    end else if (walk_end) begin
                        mode    <= SEQ_IDLE;
                        ch      <= '0;
                        cnt     <= '0;
                        fifo_en <= strap_s;
                    end else if (step_end) begin
                        cnt <= '0;
                        ch  <= ch + CH_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: mode <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dac_seq_wrgen.sv
// Module: dac_seq_wrgen
// Turns the sequencer position into register bank writes.
// Reset: four writes in the first four cycles of each channel step.
// Clear: one DAC write in the first cycle of each step.
// Purely combinational; assumes the position inputs are registered.
module dac_seq_wrgen
    import dac_seq_pkg::*;
#(
    parameter int unsigned      DATA_W         = 12,
    parameter int unsigned      CH_W           = 5,
    parameter int unsigned      CNT_W          = 3,
    parameter logic [DATA_W-1:0] GAIN_DEFAULT  = '1,
    parameter logic [DATA_W-1:0] OFFSET_DEFAULT = '0
) (
    input  seq_mode_t         mode,
    input  logic [CH_W-1:0]   ch,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] clr_value,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_ch,
    output logic [1:0]        wr_reg,
    output logic [DATA_W-1:0] wr_data
);

    // Purpose: select strobe, register code and data for this cycle.
    always_comb begin
        wr_en   = 1'b0;
        wr_ch   = ch;
        wr_reg  = REG_DAC;
        wr_data = '0;
        case (mode)
            SEQ_RESET: begin
                if (int'(cnt) < 4) begin
                    wr_en  = 1'b1;
                    wr_reg = cnt[1:0];
                    case (cnt[1:0])
                        REG_OFFSET: wr_data = OFFSET_DEFAULT;
                        REG_GAIN:   wr_data = GAIN_DEFAULT;
                        default:    wr_data = '0;
                    endcase
                end
            end
            SEQ_CLEAR: begin
                if (cnt == '0) begin
                    wr_en   = 1'b1;
                    wr_reg  = REG_DAC;
                    wr_data = clr_value;
                end
            end
            default: wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/dac_init_sequencer.sv
// Module: dac_init_sequencer (top)
// Reset/clear sequencer for a multi-channel DAC register bank.
// Synchronises the external lines, detects reset falling edges, runs the
// walk controller and drives the bank write port, busy and lockout.
// Assumes clr_value is stable while a clear walk runs.
module dac_init_sequencer
    import dac_seq_pkg::*;
#(
    parameter int unsigned       NUM_CH         = 32,
    parameter int unsigned       DATA_W         = 12,
    parameter int unsigned       STEP_CYCLES    = 8,
    parameter logic [DATA_W-1:0] GAIN_DEFAULT   = {DATA_W{1'b1}},
    parameter logic [DATA_W-1:0] OFFSET_DEFAULT = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reset_pin_n,
    input  logic                      clear_n,
    input  logic                      fifo_strap,
    input  logic [DATA_W-1:0]         clr_value,
    input  logic                      ldac_in,
    output logic                      busy_n,
    output logic                      lockout,
    output logic                      ldac_out,
    output logic                      fifo_en,
    output logic                      wr_en,
    output logic [$clog2(NUM_CH)-1:0] wr_ch,
    output logic [1:0]                wr_reg,
    output logic [DATA_W-1:0]         wr_data
);

    localparam int unsigned CH_W  = $clog2(NUM_CH);
    localparam int unsigned CNT_W = $clog2(STEP_CYCLES);

    logic [2:0]       sync_q;
    logic             rst_s;
    logic             clr_s;
    logic             strap_s;
    logic             rst_prev;
    logic             reset_fall;
    seq_mode_t        seq_mode;
    logic [CH_W-1:0]  seq_ch;
    logic [CNT_W-1:0] seq_cnt;

    dac_seq_sync #(
        .WIDTH     (3),
        .RESET_VAL (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fifo_strap, clear_n, reset_pin_n}),
        .q     (sync_q)
    );

    assign rst_s   = sync_q[0];
    assign clr_s   = sync_q[1];
    assign strap_s = sync_q[2];

    // Purpose: remember the previous synchronised reset level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_prev <= 1'b1;
        end else begin
            rst_prev <= rst_s;
        end
    end

    assign reset_fall = rst_prev && !rst_s;

    dac_seq_ctrl #(
        .NUM_CH      (NUM_CH),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_fall (reset_fall),
        .clear_low  (!clr_s),
        .strap_s    (strap_s),
        .mode       (seq_mode),
        .ch         (seq_ch),
        .cnt        (seq_cnt),
        .fifo_en    (fifo_en)
    );

    dac_seq_wrgen #(
        .DATA_W         (DATA_W),
        .CH_W           (CH_W),
        .CNT_W          (CNT_W),
        .GAIN_DEFAULT   (GAIN_DEFAULT),
        .OFFSET_DEFAULT (OFFSET_DEFAULT)
    ) u_wrgen (
        .mode      (seq_mode),
        .ch        (seq_ch),
        .cnt       (seq_cnt),
        .clr_value (clr_value),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_reg    (wr_reg),
        .wr_data   (wr_data)
    );

    // Purpose: status outputs and load-DAC gating from the registered mode.
    always_comb begin
        busy_n   = (seq_mode == SEQ_IDLE);
        lockout  = !busy_n;
        ldac_out = ldac_in && busy_n;
    end

endmodule

// File: rtl/dac_init_sequencer_chk.sv
// Module: dac_init_sequencer_chk
// Property checker bound into dac_init_sequencer. Observes ports and the
// internal mode/edge signals; drives nothing back into the design.
module dac_init_sequencer_chk
    import dac_seq_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_n,
    input logic              ldac_out,
    input logic              fifo_en,
    input logic              wr_en,
    input logic [CH_W-1:0]   wr_ch,
    input logic [1:0]        wr_reg,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] clr_value,
    input seq_mode_t         seq_mode,
    input logic              reset_fall
);

    logic [CH_W-1:0] last_ch;

    // Purpose: track the channel of the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ch <= '0;
        end else if (wr_en) begin
            last_ch <= wr_ch;
        end
    end

    assert_write_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy_n);

    assert_ldac_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> !ldac_out);

    assert_ch_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ch != last_ch && wr_ch != '0) |-> (wr_ch == last_ch + CH_W'(1)));

    assert_fifo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && $past(busy_n)) |-> $stable(fifo_en));

    assert_clear_dac_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode == SEQ_CLEAR && wr_en) |-> (wr_reg == REG_DAC && wr_data == clr_value));

    assert_reset_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode == SEQ_RESET && $past(seq_mode) != SEQ_RESET)
            |-> ($past(seq_mode) == SEQ_PWRUP || $past(reset_fall)));

endmodule

bind dac_init_sequencer dac_init_sequencer_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_n     (busy_n),
    .ldac_out   (ldac_out),
    .fifo_en    (fifo_en),
    .wr_en      (wr_en),
    .wr_ch      (wr_ch),
    .wr_reg     (wr_reg),
    .wr_data    (wr_data),
    .clr_value  (clr_value),
    .seq_mode   (seq_mode),
    .reset_fall (reset_fall)
);

// File: tb/dac_init_sequencer_bench.sv
// Directed bench for dac_init_sequencer: a model bank records every write,
// and a monitor checks write timing and channel order against the walk.
module dac_init_sequencer_bench;

    localparam int NCH  = 32;
    localparam int DW   = 12;
    localparam int STEP = 8;
    localparam int WALK = NCH * STEP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reset_pin_n = 1'b1;
    logic          clear_n = 1'b1;
    logic          fifo_strap = 1'b1;
    logic [DW-1:0] clr_value = '0;
    logic          ldac_in = 1'b0;
    logic          busy_n;
    logic          lockout;
    logic          ldac_out;
    logic          fifo_en;
    logic          wr_en;
    logic [4:0]    wr_ch;
    logic [1:0]    wr_reg;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DW-1:0] m_off  [NCH];
    logic [DW-1:0] m_gain [NCH];
    logic [DW-1:0] m_inp  [NCH];
    logic [DW-1:0] m_dac  [NCH];

    int bcyc = 0;
    int wcount = 0;
    int tm_err = 0;
    int ord_err = 0;
    int last_ch = 0;
    int exp_mode = 0;   // 0 none, 1 reset timing, 2 clear timing

    always #2 clk = ~clk;

    dac_init_sequencer #(
        .NUM_CH      (NCH),
        .DATA_W      (DW),
        .STEP_CYCLES (STEP)
    ) u_dac_init_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_pin_n (reset_pin_n),
        .clear_n     (clear_n),
        .fifo_strap  (fifo_strap),
        .clr_value   (clr_value),
        .ldac_in     (ldac_in),
        .busy_n      (busy_n),
        .lockout     (lockout),
        .ldac_out    (ldac_out),
        .fifo_en     (fifo_en),
        .wr_en       (wr_en),
        .wr_ch       (wr_ch),
        .wr_reg      (wr_reg),
        .wr_data     (wr_data)
    );

    // Monitor: model bank, write timing (R4/R5/R6) and channel order (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                wcount++;
                case (wr_reg)
                    2'd0: m_off[wr_ch]  = wr_data;
                    2'd1: m_gain[wr_ch] = wr_data;
                    2'd2: m_inp[wr_ch]  = wr_data;
                    default: m_dac[wr_ch] = wr_data;
                endcase
                if (int'(wr_ch) != last_ch && int'(wr_ch) != last_ch + 1 && wr_ch != 0)
                    ord_err++;
                last_ch = int'(wr_ch);
                if (exp_mode == 1 && bcyc != int'(wr_ch) * STEP + int'(wr_reg))
                    tm_err++;
                if (exp_mode == 2 && (wr_reg != 2'd3 || bcyc != int'(wr_ch) * STEP))
                    tm_err++;
            end
            if (!busy_n) bcyc++;
            else         bcyc = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_bank(input logic [DW-1:0] base);
        for (int i = 0; i < NCH; i++) begin
            m_off[i]  = base ^ DW'(i);
            m_gain[i] = base ^ DW'(i + 1);
            m_inp[i]  = base ^ DW'(i + 2);
            m_dac[i]  = base ^ DW'(i + 3);
        end
    endtask

    task automatic clear_counters(input int mode);
        wcount = 0; tm_err = 0; ord_err = 0; last_ch = 0; exp_mode = mode;
    endtask

    task automatic wait_fall(output int lat);
        lat = 0;
        while (busy_n && lat < 20) begin @(negedge clk); lat++; end
    endtask

    task automatic wait_rise(output int dur);
        dur = 0;
        while (!busy_n && dur < 5000) begin @(negedge clk); dur++; end
    endtask

    task automatic check_defaults(input string req);
        int bad = 0;
        for (int i = 0; i < NCH; i++)
            if (m_off[i] != 0 || m_gain[i] != 12'hFFF || m_inp[i] != 0 || m_dac[i] != 0)
                bad++;
        chk(bad == 0, req, "channels not at defaults", bad, 0);
    endtask

    task automatic t_poweron;
        int dur;
        fifo_strap = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_n && lockout, "R1", "busy/lockout in reset", {busy_n, lockout}, 2'b01);
        chk(!fifo_en && !wr_en, "R1", "fifo_en/wr_en in reset", {fifo_en, wr_en}, 0);
        fill_bank(12'h5A5);
        clear_counters(1);
        #1 rst_n = 1'b1;
        wait_rise(dur);
        chk(dur == WALK + 1, "R1", "power-on walk length", dur, WALK + 1);
        check_defaults("R4");
        chk(wcount == 4 * NCH, "R4", "power-on write count", wcount, 4 * NCH);
        chk(tm_err == 0 && ord_err == 0, "R6", "power-on write timing/order", tm_err + ord_err, 0);
        chk(fifo_en == 1'b1, "R10", "strap captured at power-on", fifo_en, 1);
    endtask

    task automatic t_reset_edge;
        int lat, dur;
        fill_bank(12'h3C3);
        fifo_strap = 1'b0;
        clear_counters(1);
        @(negedge clk) reset_pin_n = 1'b0;
        wait_fall(lat);
        chk(lat == 3, "R2", "reset edge latency", lat, 3);
        chk(lockout == 1'b1, "R3", "lockout during reset", lockout, 1);
        wait_rise(dur);
        chk(dur == WALK, "R3", "reset walk length", dur, WALK);
        check_defaults("R4");
        chk(wcount == 4 * NCH, "R4", "reset write count", wcount, 4 * NCH);
        chk(tm_err == 0 && ord_err == 0, "R6", "reset write timing/order", tm_err + ord_err, 0);
        chk(fifo_en == 1'b0, "R10", "strap recaptured after reset", fifo_en, 0);
    endtask

    task automatic t_reset_held;
        int lows = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (!busy_n) lows++; end
        chk(lows == 0, "R2", "held-low reset retriggered", lows, 0);
        reset_pin_n = 1'b1;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (!busy_n) lows++; end
        chk(lows == 0, "R2", "rising reset line started walk", lows, 0);
    endtask

    task automatic t_fifo_hold;
        fifo_strap = 1'b1;
        repeat (10) @(negedge clk);
        chk(fifo_en == 1'b0, "R10", "fifo_en changed while idle", fifo_en, 0);
    endtask

    task automatic t_clear;
        int lat, dur, bad = 0;
        fill_bank(12'h0F0);
        clr_value = 12'h5C3;
        clear_counters(2);
        @(negedge clk) clear_n = 1'b0;
        wait_fall(lat);
        clear_n = 1'b1;
        chk(lat == 3, "R5", "clear latency", lat, 3);
        wait_rise(dur);
        chk(dur == WALK, "R3", "clear walk length", dur, WALK);
        for (int i = 0; i < NCH; i++)
            if (m_dac[i] != 12'h5C3 || m_off[i] != (12'h0F0 ^ DW'(i)) ||
                m_gain[i] != (12'h0F0 ^ DW'(i + 1)) || m_inp[i] != (12'h0F0 ^ DW'(i + 2)))
                bad++;
        chk(bad == 0, "R5", "clear bank contents", bad, 0);
        chk(wcount == NCH, "R5", "clear write count", wcount, NCH);
        chk(tm_err == 0 && ord_err == 0, "R6", "clear write timing/order", tm_err + ord_err, 0);
        chk(fifo_en == 1'b1, "R10", "strap recaptured after clear", fifo_en, 1);
    endtask

    task automatic t_ldac;
        int lat, dur, seen = 0;
        @(negedge clk) ldac_in = 1'b1;
        #1 chk(ldac_out == 1'b1, "R9", "ldac passed when idle", ldac_out, 1);
        @(negedge clk) ldac_in = 1'b0;
        clear_counters(1);
        reset_pin_n = 1'b0;
        wait_fall(lat);
        repeat (20) @(negedge clk);
        ldac_in = 1'b1;
        #1 chk(ldac_out == 1'b0, "R9", "ldac leaked during busy", ldac_out, 0);
        @(negedge clk) ldac_in = 1'b0;
        wait_rise(dur);
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (ldac_out) seen++; end
        chk(seen == 0, "R9", "ldac replayed after busy", seen, 0);
        reset_pin_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_abort;
        int lat, dur, gaps = 0, bad = 0;
        fill_bank(12'h777);
        clr_value = 12'h3AB;
        clear_counters(0);
        @(negedge clk) clear_n = 1'b0;
        wait_fall(lat);
        clear_n = 1'b1;
        repeat (80) @(negedge clk);
        chk(m_dac[0] == 12'h3AB, "R7", "clear in progress before abort", m_dac[0], 12'h3AB);
        reset_pin_n = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy_n) gaps++; end
        wait_rise(dur);
        chk(gaps == 0, "R7", "busy rose during abort", gaps, 0);
        chk(dur > WALK - 8, "R7", "reset walk after abort", dur, WALK);
        for (int i = 0; i < NCH; i++)
            if (m_dac[i] != 0 || m_inp[i] != 0 || m_gain[i] != 12'hFFF) bad++;
        chk(bad == 0, "R7", "bank after aborted clear", bad, 0);
        chk(ord_err == 0, "R6", "order across abort", ord_err, 0);
        reset_pin_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_clear_in_reset;
        int lat, dur, lows = 0, bad = 0;
        clr_value = 12'h1E1;
        clear_counters(0);
        @(negedge clk) reset_pin_n = 1'b0;
        wait_fall(lat);
        clear_n = 1'b0;
        repeat (10) @(negedge clk);
        clear_n = 1'b1;
        wait_rise(dur);
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (!busy_n) lows++; end
        chk(lows == 0, "R8", "released clear acted after reset", lows, 0);
        for (int i = 0; i < NCH; i++) if (m_dac[i] != 0) bad++;
        chk(bad == 0, "R8", "dac after ignored clear", bad, 0);
        reset_pin_n = 1'b1;
        repeat (5) @(negedge clk);
        reset_pin_n = 1'b0;
        wait_fall(lat);
        clear_n = 1'b0;
        wait_rise(dur);
        @(negedge clk);
        chk(busy_n == 1'b0, "R8", "held clear follows reset after one idle cycle", busy_n, 0);
        clear_n = 1'b1;
        wait_rise(dur);
        bad = 0;
        for (int i = 0; i < NCH; i++) if (m_dac[i] != 12'h1E1) bad++;
        chk(bad == 0, "R8", "dac after follow-on clear", bad, 0);
        reset_pin_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        t_poweron();
        t_reset_edge();
        t_reset_held();
        t_fifo_hold();
        t_clear();
        t_ldac();
        t_abort();
        t_clear_in_reset();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule